// File: doc/BRIEF.md
# Parallel NOR Flash Identification Prober

This block runs the identification handshake against a parallel NOR flash device that sits behind a simple synchronous memory-bus master port. A one-cycle start pulse captures a base byte address. The block then writes the two-word unlock key followed by a reset command, writes the key again followed by the autoselect command, reads the manufacturer and device identifiers, and returns the device to array mode with one more keyed reset command. Each bus access is held until the slave raises ready.

On a 32-bit bus the block decides whether two 16-bit devices share the bus. It treats them as a pair when the upper and lower halfwords agree in both identifier reads. The identifier pair is then looked up in a parameter table of up to 16 entries, each holding a manufacturer code, a device code and a device size. The block reports found or not found, the index of the matching entry, the interleave factor, and the table size multiplied by that factor. A system controller uses this during boot, once for each candidate chip base, before it sets up any program or erase traffic.

Top module: `flprobe_top`

## Requirements
- R1: After reset, done, found, bus_wr and bus_rd are 0, match_idx is 0, ilv_count is 1 and dev_size is 0.
- R2: Every write is one of the key words or a command. The first key word (0xAA) goes to word 0x555 and the second (0x55) to word 0x2AA. Commands go to word 0x555. The byte address on bus_addr is the captured base plus the word address times BUS_BYTES.
- R3: One probe makes exactly 11 accesses in this order: key, key, reset 0xF0, key, key, autoselect 0x90, read of word 0 (manufacturer), read of word 1 (device), key, key, reset 0xF0.
- R4: On a 32-bit bus the key words always carry their byte in bits 7:0 and 23:16, with all other bits zero. The first reset and the autoselect command are replicated the same way. The final reset is replicated only when a device pair was detected; otherwise it is 0x000000F0.
- R5: On a 32-bit bus, a device pair (ilv_count = 2) is reported when the two halfwords are equal in both identifier reads, and the lower halfwords are used for the lookup. Otherwise ilv_count = 1, and a match also needs both upper halfwords to be zero.
- R6: A table entry matches only when both its manufacturer code and its device code are equal to the identifiers read. When several entries match, the lowest index is reported in match_idx.
- R7: When no entry matches, found = 0, match_idx = 0 and dev_size = 0, and the final keyed reset is still issued.
- R8: On a hit, dev_size equals the table size of the entry times ilv_count.
- R9: While ready is low, a raised strobe stays raised with bus_addr and bus_wdata unchanged. An access completes at the rising edge where ready is high, and bus_wr and bus_rd are never high together.
- R10: done is high for exactly one cycle, the cycle after the edge that completes the final reset write. The results stay unchanged until the next probe ends.
- R11: A start pulse that arrives while a probe is running has no effect.
- R12: The base address is sampled only with an accepted start, so later changes on base_addr do not move the running probe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to start a probe |
| base_addr | input | ADDR_W | Byte address of the device, sampled with start |
| bus_addr | output | ADDR_W | Byte address of the current access |
| bus_wdata | output | 8*BUS_BYTES | Write data, zero when no write is active |
| bus_rdata | input | 8*BUS_BYTES | Read data, taken at the edge where ready is high |
| bus_wr | output | 1 | Write strobe, held until ready |
| bus_rd | output | 1 | Read strobe, held until ready |
| bus_ready | input | 1 | Slave completes the current access |
| done | output | 1 | One-cycle pulse at the end of a probe |
| found | output | 1 | Identifier pair matched a table entry |
| match_idx | output | max(1,clog2(N_ENT)) | Index of the first matching entry |
| ilv_count | output | 2 | Interleave factor, 1 or 2 |
| dev_size | output | SIZE_W+1 | Table size times interleave, zero when not found |

## Verification
The assertions assume that the slave raises ready only to answer a strobe that is already up, and that reset is held across at least one clock edge before the first start. The bench responder follows both rules. It watches the strobes at the falling edge and raises ready only after a programmable number of wait cycles. It drops ready at the next falling edge, and it returns identifier data picked by whether the read address is the base or the following word. Stalls of zero, one and three cycles exercise the hold rule on both read and write accesses.

// File: rtl/flprobe_pkg.sv
package flprobe_pkg;

    typedef enum logic [1:0] {
        K_KEY  = 2'd0,
        K_CMD  = 2'd1,
        K_READ = 2'd2
    } kind_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    localparam logic [3:0]  STEP_MFR  = 4'd6;
    localparam logic [3:0]  STEP_DEV  = 4'd7;
    localparam logic [3:0]  STEP_LAST = 4'd10;

    localparam logic [11:0] WRD_KEY_A = 12'h555;
    localparam logic [11:0] WRD_KEY_B = 12'h2AA;
    localparam logic [11:0] WRD_MFR   = 12'h000;
    localparam logic [11:0] WRD_DEV   = 12'h001;

    localparam logic [7:0]  BYTE_KEY_A   = 8'hAA;
    localparam logic [7:0]  BYTE_KEY_B   = 8'h55;
    localparam logic [7:0]  BYTE_RESET   = 8'hF0;
    localparam logic [7:0]  BYTE_AUTOSEL = 8'h90;

    typedef struct packed {
        kind_e       kind;
        logic [11:0] word;
        logic [7:0]  code;
    } acc_t;

endpackage

// File: rtl/flprobe_seq.sv
module flprobe_seq
    import flprobe_pkg::*;
(
    input  logic [3:0] step,
    output acc_t       acc
);
    // Fixed access script: key pair before each command, reads in the middle.
    always_comb begin
        acc = '{kind: K_KEY, word: WRD_KEY_A, code: BYTE_KEY_A};
        unique case (step)
            4'd0, 4'd3, 4'd8: acc = '{kind: K_KEY,  word: WRD_KEY_A, code: BYTE_KEY_A};
            4'd1, 4'd4, 4'd9: acc = '{kind: K_KEY,  word: WRD_KEY_B, code: BYTE_KEY_B};
            4'd2, 4'd10:      acc = '{kind: K_CMD,  word: WRD_KEY_A, code: BYTE_RESET};
            4'd5:             acc = '{kind: K_CMD,  word: WRD_KEY_A, code: BYTE_AUTOSEL};
            4'd6:             acc = '{kind: K_READ, word: WRD_MFR,   code: 8'h00};
            4'd7:             acc = '{kind: K_READ, word: WRD_DEV,   code: 8'h00};
            default:          acc = '{kind: K_KEY,  word: WRD_KEY_A, code: BYTE_KEY_A};
        endcase
    end
endmodule

// File: rtl/flprobe_ilv.sv
module flprobe_ilv #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] mfr_raw,
    input  logic [DW-1:0] dev_raw,
    output logic          dual,
    output logic          upper_ok,
    output logic [15:0]   mfr_id,
    output logic [15:0]   dev_id
);
    generate
        if (DW == 32) begin : g_wide
            logic same_m;
            logic same_d;
            assign same_m   = (mfr_raw[31:16] == mfr_raw[15:0]);
            assign same_d   = (dev_raw[31:16] == dev_raw[15:0]);
            assign dual     = same_m && same_d;
            assign upper_ok = dual || ((mfr_raw[31:16] == 16'h0) && (dev_raw[31:16] == 16'h0));
            assign mfr_id   = mfr_raw[15:0];
            assign dev_id   = dev_raw[15:0];
        end else begin : g_narrow
            assign dual     = 1'b0;
            assign upper_ok = 1'b1;
            assign mfr_id   = 16'(mfr_raw);
            assign dev_id   = 16'(dev_raw);
        end
    endgenerate
endmodule

// File: rtl/flprobe_match.sv
module flprobe_match #(
    parameter int N_ENT  = 4,
    parameter int SIZE_W = 32,
    parameter int IDX_W  = 2,
    parameter logic [16*N_ENT-1:0]     TBL_MFR  = '0,
    parameter logic [16*N_ENT-1:0]     TBL_DEV  = '0,
    parameter logic [SIZE_W*N_ENT-1:0] TBL_SIZE = '0
) (
    input  logic              enable,
    input  logic [15:0]       mfr_id,
    input  logic [15:0]       dev_id,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx,
    output logic [SIZE_W-1:0] hit_size
);
    logic [N_ENT-1:0] eq;

    generate
        for (genvar i = 0; i < N_ENT; i++) begin : g_ent
            assign eq[i] = (TBL_MFR[16*i +: 16] == mfr_id) &&
                           (TBL_DEV[16*i +: 16] == dev_id);
        end
    endgenerate

    // Scan downwards so the lowest matching index is the last one written.
    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        hit_size = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (enable && eq[i]) begin
                hit      = 1'b1;
                hit_idx  = IDX_W'(i);
                hit_size = TBL_SIZE[SIZE_W*i +: SIZE_W];
            end
        end
    end
endmodule

// File: rtl/flprobe_top.sv
module flprobe_top
    import flprobe_pkg::*;
#(
    parameter int BUS_BYTES = 4,
    parameter int ADDR_W    = 24,
    parameter int N_ENT     = 4,
    parameter int SIZE_W    = 32,
    parameter logic [16*N_ENT-1:0] TBL_MFR =
        {16'h0004, 16'h0020, 16'h0004, 16'h0001},
    parameter logic [16*N_ENT-1:0] TBL_DEV =
        {16'h22C4, 16'h00D7, 16'h22C4, 16'h2249},
    parameter logic [SIZE_W*N_ENT-1:0] TBL_SIZE =
        {32'h0010_0000, 32'h0010_0000, 32'h0020_0000, 32'h0020_0000},
    localparam int DW    = 8 * BUS_BYTES,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DW-1:0]     bus_wdata,
    input  logic [DW-1:0]     bus_rdata,
    output logic              bus_wr,
    output logic              bus_rd,
    input  logic              bus_ready,
    output logic              done,
    output logic              found,
    output logic [IDX_W-1:0]  match_idx,
    output logic [1:0]        ilv_count,
    output logic [SIZE_W:0]   dev_size
);
    typedef struct packed {
        phase_e            phase;
        logic [3:0]        step;
        logic [ADDR_W-1:0] base;
        logic [DW-1:0]     mfr_raw;
        logic [DW-1:0]     dev_raw;
        logic              done;
        logic              found;
        logic [IDX_W-1:0]  idx;
        logic              ilv_two;
        logic [SIZE_W:0]   size;
    } st_t;

    st_t q, d;

    acc_t              acc;
    logic              dual;
    logic              upper_ok;
    logic [15:0]       mfr_id;
    logic [15:0]       dev_id;
    logic              hit;
    logic [IDX_W-1:0]  hit_idx;
    logic [SIZE_W-1:0] hit_size;
    logic [DW-1:0]     wdata_full;

    flprobe_seq u_seq (
        .step (q.step),
        .acc  (acc)
    );

    flprobe_ilv #(.DW(DW)) u_ilv (
        .mfr_raw  (q.mfr_raw),
        .dev_raw  (q.dev_raw),
        .dual     (dual),
        .upper_ok (upper_ok),
        .mfr_id   (mfr_id),
        .dev_id   (dev_id)
    );

    flprobe_match #(
        .N_ENT    (N_ENT),
        .SIZE_W   (SIZE_W),
        .IDX_W    (IDX_W),
        .TBL_MFR  (TBL_MFR),
        .TBL_DEV  (TBL_DEV),
        .TBL_SIZE (TBL_SIZE)
    ) u_match (
        .enable   (upper_ok),
        .mfr_id   (mfr_id),
        .dev_id   (dev_id),
        .hit      (hit),
        .hit_idx  (hit_idx),
        .hit_size (hit_size)
    );

    // Data lane forming: key words always doubled, commands doubled while a
    // pair is assumed (start of probe) or detected (final reset).
    generate
        if (BUS_BYTES == 4) begin : g_lane32
            logic rep;
            assign rep = (acc.kind == K_KEY) ||
                         ((acc.kind == K_CMD) && ((q.step != STEP_LAST) || dual));
            assign wdata_full = rep ? {8'h00, acc.code, 8'h00, acc.code}
                                    : {24'h000000, acc.code};
        end else begin : g_lane_narrow
            assign wdata_full = DW'(acc.code);
        end
    endgenerate

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.phase)
            PH_IDLE: begin
                if (start) begin
                    d.phase = PH_RUN;
                    d.step  = 4'd0;
                    d.base  = base_addr;
                end
            end
            PH_RUN: begin
                if (bus_ready) begin
                    if (q.step == STEP_MFR) d.mfr_raw = bus_rdata;
                    if (q.step == STEP_DEV) d.dev_raw = bus_rdata;
                    if (q.step == STEP_LAST) begin
                        d.phase   = PH_IDLE;
                        d.done    = 1'b1;
                        d.found   = hit;
                        d.idx     = hit ? hit_idx : '0;
                        d.ilv_two = dual;
                        d.size    = hit ? ({1'b0, hit_size} << dual) : '0;
                    end else begin
                        d.step = q.step + 4'd1;
                    end
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_wr    = (q.phase == PH_RUN) && (acc.kind != K_READ);
    assign bus_rd    = (q.phase == PH_RUN) && (acc.kind == K_READ);
    assign bus_addr  = q.base + (ADDR_W'(acc.word) * ADDR_W'(BUS_BYTES));
    assign bus_wdata = bus_wr ? wdata_full : '0;
    assign done      = q.done;
    assign found     = q.found;
    assign match_idx = q.idx;
    assign ilv_count = q.ilv_two ? 2'd2 : 2'd1;
    assign dev_size  = q.size;

    // R9: a stalled access keeps its strobe, address and data
    a_r9_hold_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_ready) |=> (bus_wr && $stable(bus_addr) && $stable(bus_wdata)));
    a_r9_hold_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_ready) |=> (bus_rd && $stable(bus_addr)));
    a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));
    // R10: done is a single-cycle pulse following a completed write
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r10_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(bus_wr && bus_ready));
    // R7: a miss reports no size
    a_r7_miss_size: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !found) |-> (dev_size == '0));
endmodule

// File: tb/sim_flprobe_top.sv
module sim_flprobe_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = '0;
    logic          bus_wr;
    logic          bus_rd;
    logic          bus_ready = 1'b0;
    logic          done;
    logic          found;
    logic [1:0]    match_idx;
    logic [1:0]    ilv_count;
    logic [32:0]   dev_size;

    int checks = 0;
    int fails  = 0;

    // responder state
    int            lat = 0;
    int            wcnt = 0;
    int            cyc = 0;
    int            last_ack = 0;
    logic [DW-1:0] mfr_v = '0;
    logic [DW-1:0] dev_v = '0;
    logic [AW-1:0] cur_base = '0;
    int            log_n = 0;
    logic [AW-1:0] log_addr [0:31];
    logic [DW-1:0] log_data [0:31];
    logic          log_wr   [0:31];

    always #(CLK_PERIOD/2) clk = ~clk;

    flprobe_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .base_addr (base_addr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_ready (bus_ready),
        .done      (done),
        .found     (found),
        .match_idx (match_idx),
        .ilv_count (ilv_count),
        .dev_size  (dev_size)
    );

    // Slave model: answers a raised strobe after lat wait cycles.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (bus_ready) begin
            bus_ready = 1'b0;
            wcnt = 0;
        end
        if (rst_n && (bus_wr || bus_rd)) begin
            if (wcnt >= lat) begin
                bus_ready = 1'b1;
                bus_rdata = bus_rd ? ((bus_addr == cur_base) ? mfr_v : dev_v) : '0;
                if (log_n < 32) begin
                    log_addr[log_n] = bus_addr;
                    log_data[log_n] = bus_wdata;
                    log_wr[log_n]   = bus_wr;
                end
                log_n = log_n + 1;
                last_ack = cyc;
            end else begin
                wcnt = wcnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    function automatic logic [11:0] exp_word(input int k);
        case (k)
            1, 4, 9: return 12'h2AA;
            6:       return 12'h000;
            7:       return 12'h001;
            default: return 12'h555;
        endcase
    endfunction

    function automatic logic [31:0] exp_data(input int k, input bit fdual);
        case (k)
            0, 3, 8: return 32'h00AA_00AA;
            1, 4, 9: return 32'h0055_0055;
            2:       return 32'h00F0_00F0;
            5:       return 32'h0090_0090;
            10:      return fdual ? 32'h00F0_00F0 : 32'h0000_00F0;
            default: return 32'h0;
        endcase
    endfunction

    // Runs one probe; restart_at >= 0 injects a second start mid-run.
    task automatic run_probe(input logic [AW-1:0] base, input int l,
                             input logic [31:0] m, input logic [31:0] dv,
                             input int restart_at, input logic [AW-1:0] rbase,
                             input bit e_found, input int e_idx, input int e_ilv,
                             input longint e_size);
        int n;
        logic [32:0] held_size;
        lat = l; mfr_v = m; dev_v = dv; cur_base = base; log_n = 0;
        tick();
        base_addr = base;
        start = 1'b1;
        tick();
        start = 1'b0;
        n = 0;
        while (!done && n < 400) begin
            if (n == restart_at) begin
                start = 1'b1;
                base_addr = rbase;
            end else if (n == restart_at + 1) begin
                start = 1'b0;
            end
            tick();
            n++;
        end
        start = 1'b0;
        chk(done == 1'b1, "R10", "done seen", done, 1);
        chk((cyc - last_ack) == 1, "R10", "done delay", cyc - last_ack, 1);
        chk(found == e_found, "R6", "found", found, e_found);
        chk(match_idx == e_idx, "R6", "match_idx", match_idx, e_idx);
        chk(ilv_count == e_ilv, "R5", "ilv_count", ilv_count, e_ilv);
        chk(dev_size == e_size, "R8", "dev_size", dev_size, e_size);
        // R3 count, R2 addresses, R4 data lanes
        chk(log_n == 11, "R3", "access count", log_n, 11);
        for (int k = 0; k < 11 && k < log_n; k++) begin
            logic [AW-1:0] ea;
            bit ew;
            ea = base + AW'(exp_word(k)) * 4;
            ew = (k != 6) && (k != 7);
            chk(log_addr[k] == ea, "R2", $sformatf("addr step %0d", k), log_addr[k], ea);
            chk(log_wr[k] == ew, "R3", $sformatf("kind step %0d", k), log_wr[k], ew);
            if (ew)
                chk(log_data[k] == exp_data(k, e_ilv == 2), "R4",
                    $sformatf("data step %0d", k), log_data[k], exp_data(k, e_ilv == 2));
        end
        held_size = dev_size;
        tick();
        chk(done == 1'b0, "R10", "done falls", done, 0);
        chk(found == e_found && dev_size == held_size, "R10", "results held",
            dev_size, held_size);
        chk(!bus_wr && !bus_rd, "R11", "idle after probe", {bus_wr, bus_rd}, 0);
    endtask

    task automatic t_reset();
        chk(done == 1'b0, "R1", "done", done, 0);
        chk(found == 1'b0, "R1", "found", found, 0);
        chk(!bus_wr && !bus_rd, "R1", "strobes", {bus_wr, bus_rd}, 0);
        chk(match_idx == 0, "R1", "match_idx", match_idx, 0);
        chk(ilv_count == 2'd1, "R1", "ilv_count", ilv_count, 1);
        chk(dev_size == 0, "R1", "dev_size", dev_size, 0);
    endtask

    // R6: entries 1 and 3 both match, index 1 wins; R5 pair detected
    task automatic t_dual_hit();
        run_probe(24'h010000, 0, 32'h0004_0004, 32'h22C4_22C4, -1, '0,
                  1'b1, 1, 2, 64'h40_0000);
    endtask

    // R9 stalls of three cycles; R5 single device, R4 plain final reset
    task automatic t_single_slow();
        run_probe(24'h200000, 3, 32'h0000_0020, 32'h0000_00D7, -1, '0,
                  1'b1, 2, 1, 64'h10_0000);
    endtask

    // R7: pair detected but no entry matches
    task automatic t_miss_dual();
        run_probe(24'h000000, 1, 32'h00AB_00AB, 32'h1234_1234, -1, '0,
                  1'b0, 0, 2, 64'h0);
    endtask

    // R5: lower halves match entry 0 but upper manufacturer half is non-zero
    task automatic t_upper_junk();
        run_probe(24'h080000, 0, 32'h5555_0001, 32'h0000_2249, -1, '0,
                  1'b0, 0, 1, 64'h0);
    endtask

    // R11, R12: second start with a new base while busy is ignored
    task automatic t_busy_start();
        run_probe(24'h040000, 1, 32'h0001_0001, 32'h2249_2249, 4, 24'h0F0000,
                  1'b1, 0, 2, 64'h40_0000);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL R10 watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        tick();
        tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_dual_hit();
        t_single_slow();
        t_miss_dual();
        t_upper_junk();
        t_busy_start();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule